// File: doc/BRIEF.md
# Length-aware GPS message framer

This block sits behind the receive side of a GPS receiver's serial port and works on a stream of bytes offered one at a time with a valid strobe. In the receiver's binary protocol, a message opens with two `@` characters and closes with carriage return and line feed. The payload is raw binary, so those same byte values can turn up in the middle of a message. For that reason the framer never treats them as boundaries on sight.

After the opening pair, the framer reads the two-letter command identifier and looks up the total message length for that command in a table. It counts exactly that many bytes. It then checks the XOR checksum and the terminator, and reports the frame with a good or bad status. Payload bytes go into a small message buffer that is read through a valid/ready handshake.

Every input byte is also copied, unchanged, to a pass-through output so that host software can still talk to the receiver directly.

Top module: `gps_framer`

## Requirements
- R1: Every byte accepted on `in_valid_i` appears unchanged on `pass_data_o` with `pass_valid_o` high exactly one cycle later. `pass_valid_o` is low in every cycle after a cycle with no input byte.
- R2: Hunting needs two consecutive `0x40` bytes. A byte other than `0x40` after a single `0x40` restarts the hunt. Bytes outside a frame produce no frame report.
- R3: The length table gives the total message length, counting both start bytes, the two identifier bytes, the payload, the checksum byte, CR and LF. The entries are `0x41 0x61` ("Aa") = 10, `0x42 0x62` ("Bb") = 7 and `0x43 0x63` ("Cc") = 15. The payload length is the total minus 7, and `frame_len_o` reports the total.
- R4: Payload bytes equal to `0x0D 0x0A` or `0x40 0x40` are counted as ordinary data. They neither end nor restart the frame.
- R5: When the identifier is not in the table, `unk_cmd_o` pulses for one cycle, one cycle after the second identifier byte. No frame is reported, and hunting resumes with the very next byte.
- R6: The checksum is the XOR of the two identifier bytes and all payload bytes. It is compared with the byte that follows the payload, and a mismatch gives `frame_ok_o` = 0.
- R7: If the last two bytes are not `0x0D` then `0x0A`, the frame is reported with `frame_ok_o` = 0. Hunting resumes with the byte after the frame's last counted byte.
- R8: `frame_done_o` is a one-cycle pulse, one cycle after the last counted byte. It carries `frame_ok_o`, `frame_cmd_o` (first letter in bits 15:8) and `frame_len_o`. `frame_ok_o` is high only together with the pulse.
- R9: The payload bytes of every known-length frame, good or bad, leave the buffer in arrival order on `buf_data_o` whenever `buf_valid_o` and `buf_ready_i` are both high. While `buf_ready_i` is low, the head byte is held.
- R10: A payload byte that arrives while the buffer holds `DEPTH` bytes is dropped, and that frame is reported with `frame_ok_o` = 0.
- R11: After reset, `pass_valid_o`, `buf_valid_o`, `frame_done_o`, `frame_ok_o` and `unk_cmd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input byte strobe |
| in_data_i | input | 8 | Received byte |
| pass_valid_o | output | 1 | Pass-through byte strobe |
| pass_data_o | output | 8 | Pass-through byte |
| buf_valid_o | output | 1 | Buffer holds a payload byte |
| buf_data_o | output | 8 | Head payload byte |
| buf_ready_i | input | 1 | Consumer takes the head byte |
| frame_done_o | output | 1 | Frame report pulse |
| frame_ok_o | output | 1 | Frame checksum, terminator and buffer all good |
| frame_cmd_o | output | 16 | Command identifier of the reported frame |
| frame_len_o | output | 8 | Total byte count of the reported frame |
| unk_cmd_o | output | 1 | Unknown identifier pulse |

## Verification
The framer is driven with several kinds of input:
- Clean frames of every table length, including one with an empty payload, show that counting follows the table.
- A frame whose payload holds both terminator and start-marker values tells length-driven framing apart from delimiter matching.
- Leading noise and a lone `@` separate a true start marker from a single one.
- An unknown identifier, a corrupted checksum and a corrupted LF, each followed at once by a good frame, show both the failure status and where hunting resumes.
- A long payload sent with the consumer stalled separates buffer overflow from a plain checksum error.

// File: rtl/gps_framer_pkg.sv
package gps_framer_pkg;
  localparam int LenW = 8;
  localparam int Overhead = 7;
  localparam logic [7:0] SyncByte = 8'h40;
  localparam logic [7:0] CrByte = 8'h0D;
  localparam logic [7:0] LfByte = 8'h0A;

  typedef enum logic [2:0] {
    S_HUNT1, S_HUNT2, S_CMD1, S_CMD2, S_BODY, S_CKSUM, S_CR, S_LF
  } fr_state_e;

  // total message length per command id, 0 = unknown
  function automatic logic [LenW-1:0] total_len(input logic [15:0] id);
    case (id)
      16'h4161: total_len = LenW'(10);
      16'h4262: total_len = LenW'(7);
      16'h4363: total_len = LenW'(15);
      default:  total_len = '0;
    endcase
  endfunction
endpackage

// File: rtl/gps_len_lut.sv
module gps_len_lut
  import gps_framer_pkg::*;
(
  input  logic [15:0]     id_i,
  output logic [LenW-1:0] len_o
);
  assign len_o = total_len(id_i);
endmodule

// File: rtl/gps_byte_fifo.sv
module gps_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          full_o,
  output logic          valid_o,
  output logic [DW-1:0] rdata_o,
  input  logic          ready_i
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          push, pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign rdata_o = mem_q[rp_q];
  assign push    = wr_i && !full_o;
  assign pop     = valid_o && ready_i;

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push) - (AW+1)'(pop);
    end
  end
endmodule

// File: rtl/gps_frame_fsm.sv
module gps_frame_fsm
  import gps_framer_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [7:0]      in_data_i,
  output logic [15:0]     lut_id_o,
  input  logic [LenW-1:0] lut_len_i,
  output logic            wr_o,
  input  logic            full_i,
  output logic            done_o,
  output logic            ok_o,
  output logic [15:0]     cmd_o,
  output logic [LenW-1:0] len_o,
  output logic            unk_o
);
  fr_state_e       state_q;
  logic [7:0]      c1_q, xor_q;
  logic [LenW-1:0] cnt_q;
  logic            bad_q, ovf_q;

  assign lut_id_o = {c1_q, in_data_i};
  assign wr_o     = in_valid_i && (state_q == S_BODY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HUNT1;
      c1_q    <= '0;
      xor_q   <= '0;
      cnt_q   <= '0;
      bad_q   <= 1'b0;
      ovf_q   <= 1'b0;
      done_o  <= 1'b0;
      ok_o    <= 1'b0;
      cmd_o   <= '0;
      len_o   <= '0;
      unk_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      ok_o   <= 1'b0;
      unk_o  <= 1'b0;
      if (in_valid_i) begin
        case (state_q)
          S_HUNT1: if (in_data_i == SyncByte) state_q <= S_HUNT2;
          S_HUNT2: state_q <= (in_data_i == SyncByte) ? S_CMD1 : S_HUNT1;
          S_CMD1: begin
            c1_q    <= in_data_i;
            state_q <= S_CMD2;
          end
          S_CMD2: begin
            if (lut_len_i == '0) begin
              unk_o   <= 1'b1;
              state_q <= S_HUNT1;
            end else begin
              cmd_o   <= lut_id_o;
              len_o   <= lut_len_i;
              xor_q   <= c1_q ^ in_data_i;
              cnt_q   <= lut_len_i - LenW'(Overhead);
              bad_q   <= 1'b0;
              ovf_q   <= 1'b0;
              state_q <= (lut_len_i == LenW'(Overhead)) ? S_CKSUM : S_BODY;
            end
          end
          S_BODY: begin
            xor_q <= xor_q ^ in_data_i;
            if (full_i) ovf_q <= 1'b1;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == LenW'(1)) state_q <= S_CKSUM;
          end
          S_CKSUM: begin
            if (in_data_i != xor_q) bad_q <= 1'b1;
            state_q <= S_CR;
          end
          S_CR: begin
            if (in_data_i != CrByte) bad_q <= 1'b1;
            state_q <= S_LF;
          end
          S_LF: begin
            done_o  <= 1'b1;
            ok_o    <= !bad_q && !ovf_q && (in_data_i == LfByte);
            state_q <= S_HUNT1;
          end
          default: state_q <= S_HUNT1;
        endcase
      end
    end
  end
endmodule

// File: rtl/gps_framer.sv
module gps_framer
  import gps_framer_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [7:0]      in_data_i,
  output logic            pass_valid_o,
  output logic [7:0]      pass_data_o,
  output logic            buf_valid_o,
  output logic [7:0]      buf_data_o,
  input  logic            buf_ready_i,
  output logic            frame_done_o,
  output logic            frame_ok_o,
  output logic [15:0]     frame_cmd_o,
  output logic [LenW-1:0] frame_len_o,
  output logic            unk_cmd_o
);
  logic [15:0]     lut_id;
  logic [LenW-1:0] lut_len;
  logic            fifo_wr, fifo_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_valid_o <= 1'b0;
      pass_data_o  <= '0;
    end else begin
      pass_valid_o <= in_valid_i;
      if (in_valid_i) pass_data_o <= in_data_i;
    end
  end

  gps_len_lut lut_i (.id_i(lut_id), .len_o(lut_len));

  gps_frame_fsm fsm_i (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i,
    .lut_id_o(lut_id), .lut_len_i(lut_len),
    .wr_o(fifo_wr), .full_i(fifo_full),
    .done_o(frame_done_o), .ok_o(frame_ok_o),
    .cmd_o(frame_cmd_o), .len_o(frame_len_o), .unk_o(unk_cmd_o)
  );

  gps_byte_fifo #(.DEPTH(DEPTH), .DW(8)) fifo_i (
    .clk_i, .rst_ni,
    .wr_i(fifo_wr), .wdata_i(in_data_i), .full_o(fifo_full),
    .valid_o(buf_valid_o), .rdata_o(buf_data_o), .ready_i(buf_ready_i)
  );
endmodule

// File: rtl/gps_framer_chk.sv
module gps_framer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic [7:0]  in_data_i,
  input logic        pass_valid_o,
  input logic [7:0]  pass_data_o,
  input logic        buf_valid_o,
  input logic [7:0]  buf_data_o,
  input logic        buf_ready_i,
  input logic        frame_done_o,
  input logic        frame_ok_o,
  input logic [15:0] frame_cmd_o,
  input logic [7:0]  frame_len_o,
  input logic        unk_cmd_o
);
  a_r1_pass_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (pass_valid_o && pass_data_o == $past(in_data_i)));

  a_r1_pass_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !pass_valid_o);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  a_r8_ok_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o |-> frame_done_o);

  a_r5_unk_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unk_cmd_o |-> !frame_done_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_valid_o && !buf_ready_i) |=> (buf_valid_o && $stable(buf_data_o)));
endmodule

bind gps_framer gps_framer_chk chk_i (.*);

// File: tb/gps_framer_tb_top.sv
module gps_framer_tb_top;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic buf_ready = 1'b1;
  logic pass_valid, buf_valid, frame_done, frame_ok, unk_cmd;
  logic [7:0] pass_data, buf_data, frame_len;
  logic [15:0] frame_cmd;

  int checks = 0;
  int fails = 0;
  int unk_seen = 0;

  logic [7:0]  exp_pass[$];
  logic [7:0]  exp_pay[$];
  logic [24:0] exp_fr[$];
  string       exp_tag[$];
  logic [7:0]  pl[$];

  always #4 clk = ~clk;

  gps_framer #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .pass_valid_o(pass_valid), .pass_data_o(pass_data),
    .buf_valid_o(buf_valid), .buf_data_o(buf_data), .buf_ready_i(buf_ready),
    .frame_done_o(frame_done), .frame_ok_o(frame_ok),
    .frame_cmd_o(frame_cmd), .frame_len_o(frame_len), .unk_cmd_o(unk_cmd)
  );

  task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    exp_pass.push_back(b);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // sends "@@", id, pl, checksum, CR, LF; kept = payload bytes the buffer accepts
  task automatic send_frame(input logic [7:0] c1, input logic [7:0] c2,
                            input logic [7:0] ck_flip, input logic [7:0] cr_b,
                            input logic [7:0] lf_b, input bit exp_ok,
                            input int kept, input string tag);
    logic [7:0] x;
    x = c1 ^ c2;
    foreach (pl[i]) x ^= pl[i];
    exp_fr.push_back({exp_ok, c1, c2, 8'(pl.size() + 7)});
    exp_tag.push_back(tag);
    send_byte(8'h40);
    send_byte(8'h40);
    send_byte(c1);
    send_byte(c2);
    foreach (pl[i]) begin
      if (i < kept) exp_pay.push_back(pl[i]);
      send_byte(pl[i]);
    end
    send_byte(x ^ ck_flip);
    send_byte(cr_b);
    send_byte(lf_b);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (pass_valid) begin
        if (exp_pass.size() == 0) check(1'b0, "R1 unexpected pass byte", pass_data, 0);
        else begin
          logic [7:0] e;
          e = exp_pass.pop_front();
          check(pass_data == e, "R1 pass-through byte", pass_data, e);
        end
      end
      if (buf_valid && buf_ready) begin
        if (exp_pay.size() == 0) check(1'b0, "R9 unexpected payload byte", buf_data, 0);
        else begin
          logic [7:0] e;
          e = exp_pay.pop_front();
          check(buf_data == e, "R9 payload byte order", buf_data, e);
        end
      end
      if (unk_cmd) unk_seen++;
      if (frame_done) begin
        if (exp_fr.size() == 0) check(1'b0, "R2 unexpected frame report", {frame_cmd, frame_len}, 0);
        else begin
          logic [24:0] e;
          string t;
          e = exp_fr.pop_front();
          t = exp_tag.pop_front();
          check({frame_ok, frame_cmd, frame_len} == e, {t, " frame report {ok,cmd,len} R8 R3"},
                {frame_ok, frame_cmd, frame_len}, e);
        end
      end
    end
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({pass_valid, buf_valid, frame_done, frame_ok, unk_cmd} == 5'b0,
          "R11 reset outputs", {pass_valid, buf_valid, frame_done, frame_ok, unk_cmd}, 0);

    // R2: noise and a lone '@' before a frame
    send_byte(8'h0D); send_byte(8'h0A); send_byte(8'h40); send_byte(8'h31);
    pl = '{8'h11, 8'h22, 8'h33};
    send_frame(8'h41, 8'h61, 8'h00, 8'h0D, 8'h0A, 1'b1, 99, "R2 R3 Aa");
    // R3: empty payload
    pl = '{};
    send_frame(8'h42, 8'h62, 8'h00, 8'h0D, 8'h0A, 1'b1, 99, "R3 Bb");
    idle(2);
    // R4: delimiters inside payload
    pl = '{8'h0D, 8'h0A, 8'h40, 8'h40, 8'h0D, 8'h0A, 8'h13, 8'h0A};
    send_frame(8'h43, 8'h63, 8'h00, 8'h0D, 8'h0A, 1'b1, 99, "R4 Cc");
    // R5: unknown id then a good frame at once
    send_byte(8'h40); send_byte(8'h40); send_byte(8'h5A); send_byte(8'h7A);
    pl = '{8'h40, 8'h40, 8'h01};
    send_frame(8'h41, 8'h61, 8'h00, 8'h0D, 8'h0A, 1'b1, 99, "R5 resume");
    // R6: bad checksum
    pl = '{8'hA5, 8'h5A, 8'hFF};
    send_frame(8'h41, 8'h61, 8'h01, 8'h0D, 8'h0A, 1'b0, 99, "R6 bad checksum");
    // R7: bad CR, then bad LF followed at once by a good frame
    pl = '{};
    send_frame(8'h42, 8'h62, 8'h00, 8'h0E, 8'h0A, 1'b0, 99, "R7 bad CR");
    send_frame(8'h42, 8'h62, 8'h00, 8'h0D, 8'h0B, 1'b0, 99, "R7 bad LF");
    pl = '{8'h07, 8'h08, 8'h09};
    send_frame(8'h41, 8'h61, 8'h00, 8'h0D, 8'h0A, 1'b1, 99, "R7 resume");
    send_byte(8'h40); send_byte(8'h40); send_byte(8'h41); send_byte(8'h41);
    idle(6);

    // R10: consumer stalled, long payload overflows
    @(posedge clk); #1 buf_ready = 1'b0;
    pl = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6, 8'hC7};
    send_frame(8'h43, 8'h63, 8'h00, 8'h0D, 8'h0A, 1'b0, DEPTH, "R10 overflow");
    idle(5);
    check(buf_valid == 1'b1, "R9 head held while stalled", buf_valid, 1);
    check(buf_data == 8'hC0, "R9 head byte while stalled", buf_data, 8'hC0);
    @(posedge clk); #1 buf_ready = 1'b1;
    idle(10);
    // after overflow the buffer accepts a fresh good frame
    pl = '{8'h55, 8'h66, 8'h77};
    send_frame(8'h41, 8'h61, 8'h00, 8'h0D, 8'h0A, 1'b1, 99, "R10 recover");
    idle(12);

    check(unk_seen == 2, "R5 unknown id pulses", unk_seen, 2);
    check(exp_pass.size() == 0, "R1 pass bytes outstanding", exp_pass.size(), 0);
    check(exp_fr.size() == 0, "R8 frame reports outstanding", exp_fr.size(), 0);
    check(exp_pay.size() == 0, "R9 payload bytes outstanding", exp_pay.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule